// File: doc/BRIEF.md
# Bus Data-Phase Latency Monitor

This block is a passive observer for a shared parallel bus whose handshake lines are active low: a cycle-framing line, an initiator-ready line, a target-ready line and a target-stop line. All of them are sampled on the bus clock. The monitor finds where each transaction begins and ends and numbers its data phases. For every data phase it counts how long the target and the initiator each hold off their ready line. It compares those wait times against three limits. The first applies to the target in the first data phase. The second applies to the target in every later data phase. The third applies to the initiator in every phase.

The first limit broken is latched into a sticky report. The report holds a 2-bit cause code and the 1-based index of the offending data phase. It stays until a clear pulse arrives. The monitor drives nothing on the bus. The block has no data stream, so it has no valid/ready interface: all pins are plain level signals sampled on the rising clock edge.

Top module: `dpl_monitor`

## Requirements
- R1: After reset the report reads flag 0, code 2'b00, phase 8'd0.
- R2: A transaction starts on the first edge where the framing line is low and the previous edge saw the bus idle (framing and initiator-ready both high). Data-phase clock 1 is the next edge. A data phase completes on an edge where initiator-ready and target-ready are both low, and the next phase's clock 1 is the following edge.
- R3: In data phase 1, if target-ready is still high on data-phase clock 16 (FIRST_TGT_LIMIT), code 2'b01 is latched.
- R4: In data phase 2 or later, if target-ready is still high on data-phase clock 8 (LATER_TGT_LIMIT), code 2'b10 is latched.
- R5: In any data phase, if initiator-ready is still high on data-phase clock 8 (INIT_LIMIT), code 2'b11 is latched.
- R6: When a target violation and an initiator violation occur on the same edge, the target code is latched.
- R7: Once the stop line is sampled low during a data phase, target waiting is no longer counted for the rest of that phase. Initiator waiting is still counted.
- R8: The reported phase is the 1-based index of the offending data phase, saturating at 255.
- R9: Only the first violation is kept. Later violations leave the flag, code and phase unchanged until a clear.
- R10: A high on viol_clr at an edge zeroes the flag, code and phase, unless a new violation occurs on that same edge. In that case the new violation is latched.
- R11: While the bus is idle nothing is counted. Counting resumes only after a new transaction start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle-framing line, active low |
| irdy_n | input | 1 | Initiator-ready line, active low |
| trdy_n | input | 1 | Target-ready line, active low |
| stop_n | input | 1 | Target stop request, active low |
| viol_clr | input | 1 | Clears the latched report |
| viol_flag | output | 1 | A violation is latched |
| viol_code | output | 2 | Cause: 01 first target, 10 later target, 11 initiator |
| viol_phase | output | 8 | 1-based index of the offending data phase |

## Verification
On every cycle, the assertions check the report's internal consistency. A flag is always paired with a non-zero code and phase. The report stays frozen while no clear arrives. Each newly raised cause matches the ready line that was high on the edge that raised it. Only the bench's scenarios can show where the limits fall: the exact clock a limit trips on, the first-versus-later selection, the halting effect of the stop line, the saturation at phase 255, and the clear/set collision. The bench shows these by sweeping wait lengths across each threshold and comparing against values computed from the limits.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  typedef enum logic [1:0] {
    VC_NONE      = 2'b00,
    VC_TGT_FIRST = 2'b01,
    VC_TGT_LATER = 2'b10,
    VC_INIT      = 2'b11
  } viol_code_e;
endpackage

// File: rtl/dpl_txn_track.sv
module dpl_txn_track #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic               trdy_n,
  output logic               addr_phase,
  output logic               data_clk,
  output logic               phase_done,
  output logic               first_phase,
  output logic [PHASE_W-1:0] phase_num
);
  localparam logic [PHASE_W-1:0] PH_MAX = {PHASE_W{1'b1}};
  localparam logic [PHASE_W-1:0] PH_ONE = PHASE_W'(1);

  logic idle_q, active_q, first_q;
  logic [PHASE_W-1:0] num_q;
  logic bus_idle;

  // idle means both framing and initiator-ready are released
  assign bus_idle    = frame_n & irdy_n;
  assign addr_phase  = ~frame_n & idle_q;
  assign data_clk    = active_q & ~bus_idle;
  assign phase_done  = data_clk & ~irdy_n & ~trdy_n;
  assign first_phase = first_q;
  assign phase_num   = num_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= 1'b1;
      active_q <= 1'b0;
      first_q  <= 1'b0;
      num_q    <= '0;
    end else begin
      idle_q <= bus_idle;
      if (addr_phase) begin
        active_q <= 1'b1;
        first_q  <= 1'b1;
        num_q    <= PH_ONE;
      end else begin
        if (bus_idle) active_q <= 1'b0;
        if (phase_done) begin
          first_q <= 1'b0;
          if (num_q != PH_MAX) num_q <= num_q + PH_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/dpl_wait_cnt.sv
module dpl_wait_cnt #(
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              data_clk,
  input  logic              waiting,
  input  logic              halt_req,
  input  logic [WAIT_W-1:0] limit,
  output logic              hit
);
  localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt_q;
  logic halt_q, count_en;

  // halt_req freezes counting for the remainder of the phase
  assign count_en = data_clk & waiting & ~halt_req & ~halt_q;
  assign hit      = count_en & (cnt_q == limit - W_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (data_clk & halt_req) halt_q <= 1'b1;
      if (count_en && cnt_q != limit) cnt_q <= cnt_q + W_ONE;
    end
  end
endmodule

// File: rtl/dpl_viol_latch.sv
module dpl_viol_latch
  import dpl_pkg::*;
#(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_hit,
  input  logic               tgt_first,
  input  logic               init_hit,
  input  logic [PHASE_W-1:0] phase_num,
  input  logic               clr,
  output logic               flag,
  output viol_code_e         code,
  output logic [PHASE_W-1:0] phase
);
  logic       any_hit, take_new;
  viol_code_e new_code;

  assign any_hit  = tgt_hit | init_hit;
  assign take_new = any_hit & (~flag | clr);

  always_comb begin
    if (tgt_hit) new_code = tgt_first ? VC_TGT_FIRST : VC_TGT_LATER;
    else         new_code = VC_INIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      code  <= VC_NONE;
      phase <= '0;
    end else if (take_new) begin
      flag  <= 1'b1;
      code  <= new_code;
      phase <= phase_num;
    end else if (clr) begin
      flag  <= 1'b0;
      code  <= VC_NONE;
      phase <= '0;
    end
  end
endmodule

// File: rtl/dpl_monitor.sv
module dpl_monitor
  import dpl_pkg::*;
#(
  parameter int FIRST_TGT_LIMIT = 16,
  parameter int LATER_TGT_LIMIT = 8,
  parameter int INIT_LIMIT      = 8,
  parameter int PHASE_W         = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic               trdy_n,
  input  logic               stop_n,
  input  logic               viol_clr,
  output logic               viol_flag,
  output logic [1:0]         viol_code,
  output logic [PHASE_W-1:0] viol_phase
);
  localparam int TGT_MAX = (FIRST_TGT_LIMIT > LATER_TGT_LIMIT) ? FIRST_TGT_LIMIT : LATER_TGT_LIMIT;
  localparam int ALL_MAX = (TGT_MAX > INIT_LIMIT) ? TGT_MAX : INIT_LIMIT;
  localparam int WAIT_W  = $clog2(ALL_MAX + 1);

  logic addr_phase, data_clk, phase_done, first_phase, restart;
  logic tgt_hit, init_hit;
  logic [PHASE_W-1:0] phase_num;
  logic [WAIT_W-1:0]  tgt_limit;
  viol_code_e         code_e;

  dpl_txn_track #(.PHASE_W(PHASE_W)) u_track (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .addr_phase(addr_phase), .data_clk(data_clk), .phase_done(phase_done),
    .first_phase(first_phase), .phase_num(phase_num)
  );

  assign restart   = addr_phase | phase_done;
  assign tgt_limit = first_phase ? WAIT_W'(FIRST_TGT_LIMIT) : WAIT_W'(LATER_TGT_LIMIT);

  dpl_wait_cnt #(.WAIT_W(WAIT_W)) u_tgt_wait (
    .clk(clk), .rst_n(rst_n), .restart(restart), .data_clk(data_clk),
    .waiting(trdy_n), .halt_req(~stop_n), .limit(tgt_limit), .hit(tgt_hit)
  );

  dpl_wait_cnt #(.WAIT_W(WAIT_W)) u_init_wait (
    .clk(clk), .rst_n(rst_n), .restart(restart), .data_clk(data_clk),
    .waiting(irdy_n), .halt_req(1'b0), .limit(WAIT_W'(INIT_LIMIT)), .hit(init_hit)
  );

  dpl_viol_latch #(.PHASE_W(PHASE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .tgt_hit(tgt_hit), .tgt_first(first_phase),
    .init_hit(init_hit), .phase_num(phase_num), .clr(viol_clr),
    .flag(viol_flag), .code(code_e), .phase(viol_phase)
  );

  assign viol_code = code_e;
endmodule

// File: rtl/dpl_monitor_chk.sv
module dpl_monitor_chk #(
  parameter int PHASE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irdy_n,
  input logic               trdy_n,
  input logic               stop_n,
  input logic               viol_clr,
  input logic               viol_flag,
  input logic [1:0]         viol_code,
  input logic [PHASE_W-1:0] viol_phase
);
  assert_code_pairs_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag == (viol_code != 2'b00));

  assert_phase_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |-> viol_phase != '0);

  assert_report_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> (viol_flag && $stable(viol_code) && $stable(viol_phase)));

  assert_target_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(viol_flag) && viol_code[1] != viol_code[0]) |-> ($past(trdy_n) && $past(stop_n)));

  assert_initiator_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(viol_flag) && viol_code == 2'b11) |-> $past(irdy_n));

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(viol_flag) == 1'b0 && $fell(viol_flag)) |-> $past(viol_clr));
endmodule

bind dpl_monitor dpl_monitor_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n),
  .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_code(viol_code), .viol_phase(viol_phase)
);

// File: tb/test_dpl_monitor.sv
module test_dpl_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 16, LL = 8, IL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, viol_clr = 1'b0;
  logic viol_flag;
  logic [1:0] viol_code;
  logic [7:0] viol_phase;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpl_monitor i_dpl_monitor (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .viol_clr(viol_clr), .viol_flag(viol_flag),
    .viol_code(viol_code), .viol_phase(viol_phase)
  );

  task automatic check(string req, logic [10:0] exp);
    logic [10:0] act;
    @(negedge clk);
    act = {viol_flag, viol_code, viol_phase};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got flag=%0d code=%0d phase=%0d expected flag=%0d code=%0d phase=%0d",
               req, act[10], act[9:8], act[7:0], exp[10], exp[9:8], exp[7:0]);
    end
  endtask

  task automatic idle(int n, bit clr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; viol_clr = clr;
    end
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  task automatic addr();
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; viol_clr = 1'b0;
  endtask

  // one data phase; tw/iw = wait clocks before target/initiator ready
  task automatic phase(int tw, int iw, bit last, bit use_stop, int clr_k);
    int k = 1;
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      irdy_n   = (k <= iw);
      trdy_n   = use_stop ? 1'b1 : (k <= tw);
      stop_n   = !(use_stop && k >= 3);
      frame_n  = last && (k > iw);
      viol_clr = (k == clr_k);
      done     = use_stop ? (k >= tw) : ((k > iw) && (k > tw));
      k++;
    end
  endtask

  function automatic logic [10:0] rep(bit f, int c, int p);
    return {f, 2'(c), 8'(p)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", rep(0, 0, 0));

    // R3: sweep first-phase target wait across the limit
    for (int w = 0; w <= FL + 2; w++) begin
      idle(2, 1'b0); addr(); phase(w, 0, 1'b1, 1'b0, 0); idle(2, 1'b0);
      check("R3 first target wait", (w >= FL) ? rep(1, 1, 1) : rep(0, 0, 0));
      idle(1, 1'b1);
    end

    // R4 and R2: phase 1 waits 3, phase 2 sweeps; counter must restart per phase
    for (int w = 0; w <= LL + 2; w++) begin
      idle(2, 1'b0); addr(); phase(3, 0, 1'b0, 1'b0, 0); phase(w, 0, 1'b1, 1'b0, 0); idle(2, 1'b0);
      check("R4 later target wait", (w >= LL) ? rep(1, 2, 2) : rep(0, 0, 0));
      idle(1, 1'b1);
    end

    // R5: initiator wait sweep in phase 1
    for (int w = 0; w <= IL + 2; w++) begin
      idle(2, 1'b0); addr(); phase(0, w, 1'b1, 1'b0, 0); idle(2, 1'b0);
      check("R5 initiator wait", (w >= IL) ? rep(1, 3, 1) : rep(0, 0, 0));
      idle(1, 1'b1);
    end

    // R7: stop halts target counting
    idle(2, 1'b0); addr(); phase(FL + 4, 0, 1'b1, 1'b1, 0); idle(2, 1'b0);
    check("R7 stop halts target count", rep(0, 0, 0));
    idle(1, 1'b1);

    // R6: simultaneous target and initiator violation
    idle(2, 1'b0); addr(); phase(0, 0, 1'b0, 1'b0, 0); phase(LL + 2, IL + 2, 1'b1, 1'b0, 0); idle(2, 1'b0);
    check("R6 target wins tie", rep(1, 2, 2));
    idle(1, 1'b1);

    // R9: first violation kept
    idle(2, 1'b0); addr(); phase(0, IL + 1, 1'b0, 1'b0, 0); phase(LL + 1, 0, 1'b1, 1'b0, 0); idle(2, 1'b0);
    check("R9 first kept", rep(1, 3, 1));

    // R10: clear collides with a new violation at clock FL
    idle(2, 1'b0); addr(); phase(FL + 1, 0, 1'b1, 1'b0, FL); idle(2, 1'b0);
    check("R10 set beats clear", rep(1, 1, 1));
    idle(1, 1'b1);
    check("R10 clear alone", rep(0, 0, 0));

    // R11: long idle with target-ready high counts nothing
    idle(FL * 3, 1'b0);
    check("R11 idle ignored", rep(0, 0, 0));

    // R8: phase index reported, then saturated
    idle(2, 1'b0); addr();
    for (int p = 1; p < 200; p++) phase(0, 0, 1'b0, 1'b0, 0);
    phase(0, IL + 1, 1'b1, 1'b0, 0); idle(2, 1'b0);
    check("R8 phase index 200", rep(1, 3, 200));
    idle(1, 1'b1);
    idle(2, 1'b0); addr();
    for (int p = 1; p < 300; p++) phase(0, 0, 1'b0, 1'b0, 0);
    phase(0, IL + 1, 1'b1, 1'b0, 0); idle(2, 1'b0);
    check("R8 phase index saturates", rep(1, 3, 255));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule